// File: doc/BRIEF.md
# CAN receive mailbox matching engine

This block decides where a received CAN frame lands. While the frame's CRC field is on the bus, it walks an array of receive mailboxes in ascending index order, one mailbox per clock. It compares the staged identifier against each mailbox's identifier under that mailbox's own acceptance mask, and picks a target. At the sixth bit of End-Of-Frame it issues a single move-in write that names the target mailbox and the new code value. A protocol error flagged during the frame cancels the move-in.

In queueing mode, a matching mailbox that still holds an unread frame is passed over. Later matches can then act as a reception queue. When no match is free, the last match is overwritten and marked OVERRUN. If that mailbox is held by the CPU, the frame waits in the staging buffer and is written as soon as the CPU releases it. In legacy mode the search ends at the first match, whether that mailbox is free or not.

The block holds each mailbox's code, identifier, mask, service flag and the single CPU lock. Software programs these through a configuration write port and lock/unlock strobes.

Top module: `canmb_match_top`

## Requirements
- R1: While reset is asserted, every mailbox code reads 0 (INACTIVE) and `mv_en` is 0.
- R2: An identifier bit takes part in matching only where the mailbox's mask bit is 1. Where the mask bit is 0, that identifier bit is ignored.
- R3: Only mailboxes with a receive code take part in matching: EMPTY = 4'h4, FULL = 4'h2 or OVERRUN = 4'h6. Mailboxes with any other code are skipped and keep their code.
- R4: In queueing mode (`queue_mode` = 1), the frame goes to the lowest-index matching mailbox that is free, with code FULL (2). A mailbox is free when it is unlocked and either EMPTY, or FULL/OVERRUN and serviced.
- R5: In queueing mode, when no matching mailbox is free, the highest-index match is written with code OVERRUN (6).
- R6: A FULL or OVERRUN mailbox becomes serviced once it is locked (`cpu_lock` with `cpu_idx`) and then unlocked (`cpu_unlock`). A later move-in into it writes FULL. Any move-in or configuration write clears the service flag.
- R7: In legacy mode (`queue_mode` = 0), the frame goes to the lowest-index match even when that mailbox is not free. It then gets OVERRUN if unserviced.
- R8: A frame for which `rx_err` pulses between `rx_start` and the move-in bit causes no move-in, and leaves all codes unchanged.
- R9: The move-in is a one-cycle pulse of `mv_en`, registered on the clock edge that samples `eof_tick` with `eof_bit` = 5 (the sixth End-Of-Frame bit, counted from 0).
- R10: When the chosen mailbox is locked at the move-in bit, no write happens then. The frame is written to that mailbox on the edge after the lock is seen released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| queue_mode | input | 1 | 1 = queueing search, 0 = legacy first-match search |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Mailbox being configured |
| cfg_code | input | 4 | Code value to write |
| cfg_id | input | ID_W | Identifier to write |
| cfg_mask | input | ID_W | Acceptance mask to write (1 = compare) |
| cpu_lock | input | 1 | CPU reads a mailbox control/status word and locks it |
| cpu_unlock | input | 1 | CPU releases the lock |
| cpu_idx | input | IDX_W | Mailbox targeted by `cpu_lock` |
| rx_start | input | 1 | Pulse at the start of the CRC field; the staged identifier is valid |
| rx_id | input | ID_W | Identifier of the staged frame |
| rx_err | input | 1 | Protocol error pulse for the current frame |
| eof_tick | input | 1 | One-cycle strobe per End-Of-Frame bit |
| eof_bit | input | 3 | Index of the current End-Of-Frame bit, from 0 |
| mv_en | output | 1 | Move-in write pulse |
| mv_idx | output | IDX_W | Target mailbox of the move-in |
| mv_code | output | 4 | Code written by the move-in |
| mb_code_o | output | NUM_MB*4 | All mailbox codes, mailbox i in bits [4i+3:4i] |

## Verification
The bench first sends three frames with the same identifier to two mailboxes. A design that stopped at the first match would send all three to mailbox 2. A design that ignored the service flag would never produce OVERRUN. A transmit-coded and an inactive mailbox share that identifier and must not change; a design that skipped the code check would write into them. The bench then services a mailbox and expects FULL, since a design that never set the service flag would write OVERRUN. It then switches to legacy mode while a later mailbox is free, where a queueing search would wrongly choose the later one. The remaining stimuli cover a masked range hit and a near miss, an errored frame that must leave everything untouched, and a locked last match that must stay silent at End-Of-Frame and be written exactly one edge after unlock.

// File: rtl/canmb_pkg.sv
package canmb_pkg;
  localparam int CODE_W   = 4;
  localparam int EOFCNT_W = 3;

  localparam logic [CODE_W-1:0] MBC_INACTIVE = 4'h0;
  localparam logic [CODE_W-1:0] MBC_FULL     = 4'h2;
  localparam logic [CODE_W-1:0] MBC_EMPTY    = 4'h4;
  localparam logic [CODE_W-1:0] MBC_OVERRUN  = 4'h6;

  function automatic logic code_is_rx(input logic [CODE_W-1:0] c);
    return (c == MBC_EMPTY) || (c == MBC_FULL) || (c == MBC_OVERRUN);
  endfunction

  function automatic logic code_holds_frame(input logic [CODE_W-1:0] c);
    return (c == MBC_FULL) || (c == MBC_OVERRUN);
  endfunction
endpackage

// File: rtl/canmb_state.sv
module canmb_state
  import canmb_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int ID_W   = 11,
  parameter int IDX_W  = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  logic [CODE_W-1:0]                 cfg_code,
  input  logic [ID_W-1:0]                   cfg_id,
  input  logic [ID_W-1:0]                   cfg_mask,
  input  logic                              cpu_lock,
  input  logic                              cpu_unlock,
  input  logic [IDX_W-1:0]                  cpu_idx,
  input  logic                              mv_en,
  input  logic [IDX_W-1:0]                  mv_idx,
  input  logic [CODE_W-1:0]                 mv_code,
  output logic [NUM_MB-1:0][CODE_W-1:0]     code_o,
  output logic [NUM_MB-1:0][ID_W-1:0]       id_o,
  output logic [NUM_MB-1:0][ID_W-1:0]       mask_o,
  output logic [NUM_MB-1:0]                 free_o,
  output logic                              lock_vld_o,
  output logic [IDX_W-1:0]                  lock_idx_o
);

  logic [NUM_MB-1:0][CODE_W-1:0] code_q, code_d;
  logic [NUM_MB-1:0][ID_W-1:0]   id_q, mask_q;
  logic [NUM_MB-1:0]             svc_q, svc_d;
  logic                          lock_vld_q, lock_vld_d;
  logic [IDX_W-1:0]              lock_idx_q, lock_idx_d;

  // Next-state: unlock, then lock (read of control/status), then move-in,
  // then software configuration, which has the last word.
  always_comb begin
    code_d     = code_q;
    svc_d      = svc_q;
    lock_vld_d = lock_vld_q;
    lock_idx_d = lock_idx_q;
    if (cpu_unlock) begin
      lock_vld_d = 1'b0;
    end
    if (cpu_lock) begin
      lock_vld_d = 1'b1;
      lock_idx_d = cpu_idx;
      if (code_holds_frame(code_q[cpu_idx])) begin
        svc_d[cpu_idx] = 1'b1;
      end
    end
    if (mv_en) begin
      code_d[mv_idx] = mv_code;
      svc_d[mv_idx]  = 1'b0;
    end
    if (cfg_we) begin
      code_d[cfg_idx] = cfg_code;
      svc_d[cfg_idx]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q     <= '0;
      svc_q      <= '0;
      lock_vld_q <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      code_q     <= code_d;
      svc_q      <= svc_d;
      lock_vld_q <= lock_vld_d;
      lock_idx_q <= lock_idx_d;
    end
  end

  // Identifier and mask storage behaves like RAM: no reset, write enable only.
  always_ff @(posedge clk) begin
    if (cfg_we) begin
      id_q[cfg_idx]   <= cfg_id;
      mask_q[cfg_idx] <= cfg_mask;
    end
  end

  generate
    for (genvar g = 0; g < NUM_MB; g++) begin : g_free
      logic held_by_cpu;
      assign held_by_cpu = lock_vld_q && (lock_idx_q == IDX_W'(g));
      assign free_o[g]   = !held_by_cpu &&
                           ((code_q[g] == MBC_EMPTY) ||
                            (code_holds_frame(code_q[g]) && svc_q[g]));
    end
  endgenerate

  assign code_o     = code_q;
  assign id_o       = id_q;
  assign mask_o     = mask_q;
  assign lock_vld_o = lock_vld_q;
  assign lock_idx_o = lock_idx_q;

  // R4: a move-in lands in the addressed mailbox's code on the next edge
  p_movein_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_en && !cfg_we) |=> (code_q[$past(mv_idx)] == $past(mv_code)));

endmodule

// File: rtl/canmb_scan.sv
module canmb_scan
  import canmb_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int ID_W   = 11,
  parameter int IDX_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [ID_W-1:0]               rx_id,
  input  logic                          queue_mode,
  input  logic [NUM_MB-1:0][CODE_W-1:0] code_i,
  input  logic [NUM_MB-1:0][ID_W-1:0]   id_i,
  input  logic [NUM_MB-1:0][ID_W-1:0]   mask_i,
  input  logic [NUM_MB-1:0]             free_i,
  output logic                          done_o,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MB - 1);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic [ID_W-1:0]   key_q, key_d;
  logic              first_f_q, first_f_d;
  logic [IDX_W-1:0]  first_idx_q, first_idx_d;
  logic [IDX_W-1:0]  last_idx_q, last_idx_d;
  logic              free_f_q, free_f_d;
  logic [IDX_W-1:0]  free_idx_q, free_idx_d;
  logic              cur_hit;

  assign cur_hit = code_is_rx(code_i[ptr_q]) &&
                   (((id_i[ptr_q] ^ key_q) & mask_i[ptr_q]) == '0);

  always_comb begin
    busy_d      = busy_q;
    done_d      = done_q;
    ptr_d       = ptr_q;
    key_d       = key_q;
    first_f_d   = first_f_q;
    first_idx_d = first_idx_q;
    last_idx_d  = last_idx_q;
    free_f_d    = free_f_q;
    free_idx_d  = free_idx_q;
    if (start) begin
      busy_d    = 1'b1;
      done_d    = 1'b0;
      ptr_d     = '0;
      key_d     = rx_id;
      first_f_d = 1'b0;
      free_f_d  = 1'b0;
    end else if (busy_q) begin
      if (cur_hit) begin
        if (!first_f_q) begin
          first_f_d   = 1'b1;
          first_idx_d = ptr_q;
        end
        last_idx_d = ptr_q;
        if (free_i[ptr_q] && !free_f_q) begin
          free_f_d   = 1'b1;
          free_idx_d = ptr_q;
        end
      end
      // Legacy search ends at the first match; queueing walks the whole array.
      if ((ptr_q == LAST_IDX) || (!queue_mode && cur_hit)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        ptr_d = ptr_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      ptr_q       <= '0;
      key_q       <= '0;
      first_f_q   <= 1'b0;
      first_idx_q <= '0;
      last_idx_q  <= '0;
      free_f_q    <= 1'b0;
      free_idx_q  <= '0;
    end else begin
      busy_q      <= busy_d;
      done_q      <= done_d;
      ptr_q       <= ptr_d;
      key_q       <= key_d;
      first_f_q   <= first_f_d;
      first_idx_q <= first_idx_d;
      last_idx_q  <= last_idx_d;
      free_f_q    <= free_f_d;
      free_idx_q  <= free_idx_d;
    end
  end

  assign done_o = done_q;
  assign hit_o  = done_q && first_f_q;
  assign idx_o  = !queue_mode ? first_idx_q :
                  (free_f_q ? free_idx_q : last_idx_q);

endmodule

// File: rtl/canmb_movein.sv
module canmb_movein
  import canmb_pkg::*;
#(
  parameter int NUM_MB       = 8,
  parameter int IDX_W        = 3,
  parameter int EOF_MOVE_BIT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_start,
  input  logic                rx_err,
  input  logic                eof_tick,
  input  logic [EOFCNT_W-1:0] eof_bit,
  input  logic                scan_done,
  input  logic                scan_hit,
  input  logic [IDX_W-1:0]    scan_idx,
  input  logic                lock_vld,
  input  logic [IDX_W-1:0]    lock_idx,
  input  logic [NUM_MB-1:0]   free_i,
  output logic                mv_en,
  output logic [IDX_W-1:0]    mv_idx,
  output logic [CODE_W-1:0]   mv_code
);

  localparam logic [EOFCNT_W-1:0] MOVE_BIT = EOFCNT_W'(EOF_MOVE_BIT);

  logic              act_q, act_d;
  logic              pend_q, pend_d;
  logic [IDX_W-1:0]  pend_idx_q, pend_idx_d;
  logic              mv_en_q, mv_en_d;
  logic [IDX_W-1:0]  mv_idx_q, mv_idx_d;
  logic [CODE_W-1:0] mv_code_q, mv_code_d;
  logic              move_bit;
  logic              scan_locked, pend_locked;

  assign move_bit    = eof_tick && (eof_bit == MOVE_BIT);
  assign scan_locked = lock_vld && (lock_idx == scan_idx);
  assign pend_locked = lock_vld && (lock_idx == pend_idx_q);

  always_comb begin
    act_d      = act_q;
    pend_d     = pend_q;
    pend_idx_d = pend_idx_q;
    mv_en_d    = 1'b0;
    mv_idx_d   = mv_idx_q;
    mv_code_d  = mv_code_q;
    if (rx_start) begin
      // A new frame takes over the staging buffer.
      act_d  = 1'b1;
      pend_d = 1'b0;
    end else if (act_q && rx_err) begin
      act_d = 1'b0;
    end else if (act_q && move_bit) begin
      act_d = 1'b0;
      if (scan_done && scan_hit) begin
        if (scan_locked) begin
          pend_d     = 1'b1;
          pend_idx_d = scan_idx;
        end else begin
          mv_en_d   = 1'b1;
          mv_idx_d  = scan_idx;
          mv_code_d = free_i[scan_idx] ? MBC_FULL : MBC_OVERRUN;
        end
      end
    end else if (pend_q && !pend_locked) begin
      pend_d    = 1'b0;
      mv_en_d   = 1'b1;
      mv_idx_d  = pend_idx_q;
      mv_code_d = free_i[pend_idx_q] ? MBC_FULL : MBC_OVERRUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      mv_en_q    <= 1'b0;
      mv_idx_q   <= '0;
      mv_code_q  <= MBC_INACTIVE;
    end else begin
      act_q      <= act_d;
      pend_q     <= pend_d;
      pend_idx_q <= pend_idx_d;
      mv_en_q    <= mv_en_d;
      mv_idx_q   <= mv_idx_d;
      mv_code_q  <= mv_code_d;
    end
  end

  assign mv_en   = mv_en_q;
  assign mv_idx  = mv_idx_q;
  assign mv_code = mv_code_q;

  // R10: a move-in never targets a mailbox that was locked when it was decided
  p_target_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mv_en_q |-> (!$past(lock_vld) || ($past(lock_idx) != mv_idx_q)));

  // R8: an error during a live frame suppresses its move-in
  p_err_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && rx_err && !rx_start) |=> !mv_en_q);

  // R9: the move-in strobe lasts one cycle
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mv_en_q |=> !mv_en_q);

endmodule

// File: rtl/canmb_match_top.sv
module canmb_match_top
  import canmb_pkg::*;
#(
  parameter  int NUM_MB       = 8,
  parameter  int ID_W         = 11,
  parameter  int EOF_MOVE_BIT = 5,
  localparam int IDX_W        = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     queue_mode,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [3:0]               cfg_code,
  input  logic [ID_W-1:0]          cfg_id,
  input  logic [ID_W-1:0]          cfg_mask,
  input  logic                     cpu_lock,
  input  logic                     cpu_unlock,
  input  logic [IDX_W-1:0]         cpu_idx,
  input  logic                     rx_start,
  input  logic [ID_W-1:0]          rx_id,
  input  logic                     rx_err,
  input  logic                     eof_tick,
  input  logic [2:0]               eof_bit,
  output logic                     mv_en,
  output logic [IDX_W-1:0]         mv_idx,
  output logic [3:0]               mv_code,
  output logic [NUM_MB*4-1:0]      mb_code_o
);

  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_sync_q[1];

  logic [NUM_MB-1:0][CODE_W-1:0] code_w;
  logic [NUM_MB-1:0][ID_W-1:0]   id_w, mask_w;
  logic [NUM_MB-1:0]             free_w;
  logic                          lock_vld_w;
  logic [IDX_W-1:0]              lock_idx_w;
  logic                          scan_done_w, scan_hit_w;
  logic [IDX_W-1:0]              scan_idx_w;

  canmb_state #(.NUM_MB(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_sn),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_code   (cfg_code),
    .cfg_id     (cfg_id),
    .cfg_mask   (cfg_mask),
    .cpu_lock   (cpu_lock),
    .cpu_unlock (cpu_unlock),
    .cpu_idx    (cpu_idx),
    .mv_en      (mv_en),
    .mv_idx     (mv_idx),
    .mv_code    (mv_code),
    .code_o     (code_w),
    .id_o       (id_w),
    .mask_o     (mask_w),
    .free_o     (free_w),
    .lock_vld_o (lock_vld_w),
    .lock_idx_o (lock_idx_w)
  );

  canmb_scan #(.NUM_MB(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_sn),
    .start      (rx_start),
    .rx_id      (rx_id),
    .queue_mode (queue_mode),
    .code_i     (code_w),
    .id_i       (id_w),
    .mask_i     (mask_w),
    .free_i     (free_w),
    .done_o     (scan_done_w),
    .hit_o      (scan_hit_w),
    .idx_o      (scan_idx_w)
  );

  canmb_movein #(.NUM_MB(NUM_MB), .IDX_W(IDX_W), .EOF_MOVE_BIT(EOF_MOVE_BIT)) u_movein (
    .clk       (clk),
    .rst_n     (rst_sn),
    .rx_start  (rx_start),
    .rx_err    (rx_err),
    .eof_tick  (eof_tick),
    .eof_bit   (eof_bit),
    .scan_done (scan_done_w),
    .scan_hit  (scan_hit_w),
    .scan_idx  (scan_idx_w),
    .lock_vld  (lock_vld_w),
    .lock_idx  (lock_idx_w),
    .free_i    (free_w),
    .mv_en     (mv_en),
    .mv_idx    (mv_idx),
    .mv_code   (mv_code)
  );

  assign mb_code_o = code_w;

endmodule

// File: tb/canmb_match_top_tb_top.sv
module canmb_match_top_tb_top;
  localparam int NUM_MB = 8;
  localparam int ID_W   = 11;
  localparam int IDX_W  = 3;
  localparam logic [3:0] C_INACT = 4'h0, C_FULL = 4'h2, C_EMPTY = 4'h4,
                         C_OVR = 4'h6, C_TX = 4'hC;

  logic clk = 1'b0;
  logic rst_n;
  logic queue_mode, cfg_we, cpu_lock, cpu_unlock, rx_start, rx_err, eof_tick;
  logic [IDX_W-1:0] cfg_idx, cpu_idx, mv_idx;
  logic [3:0] cfg_code, mv_code;
  logic [ID_W-1:0] cfg_id, cfg_mask, rx_id;
  logic [2:0] eof_bit;
  logic mv_en;
  logic [NUM_MB*4-1:0] mb_code_o;

  int checks = 0;
  int failures = 0;

  typedef struct { int idx; int code; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  canmb_match_top #(.NUM_MB(NUM_MB), .ID_W(ID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .queue_mode(queue_mode),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code),
    .cfg_id(cfg_id), .cfg_mask(cfg_mask),
    .cpu_lock(cpu_lock), .cpu_unlock(cpu_unlock), .cpu_idx(cpu_idx),
    .rx_start(rx_start), .rx_id(rx_id), .rx_err(rx_err),
    .eof_tick(eof_tick), .eof_bit(eof_bit),
    .mv_en(mv_en), .mv_idx(mv_idx), .mv_code(mv_code), .mb_code_o(mb_code_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int code_of(input int i);
    return int'(mb_code_o[i*4 +: 4]);
  endfunction

  task automatic expect_mv(input int idx, input int code, input string tag);
    exp_t e;
    e.idx = idx; e.code = code; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops the scoreboard on every move-in pulse
  always @(negedge clk) begin
    if (rst_n && mv_en) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL unexpected move-in actual=%0d expected=none (R8/R2)", mv_idx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " mv_idx"}, int'(mv_idx), e.idx);
        chk({e.tag, " mv_code"}, int'(mv_code), e.code);
      end
    end
  end

  task automatic cfg(input int idx, input logic [3:0] code,
                     input logic [ID_W-1:0] id, input logic [ID_W-1:0] mask);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_code = code; cfg_id = id; cfg_mask = mask;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lock_mb(input int idx);
    @(negedge clk);
    cpu_lock = 1'b1; cpu_idx = IDX_W'(idx);
    @(negedge clk);
    cpu_lock = 1'b0;
  endtask

  task automatic unlock_mb();
    @(negedge clk);
    cpu_unlock = 1'b1;
    @(negedge clk);
    cpu_unlock = 1'b0;
  endtask

  task automatic frame(input logic [ID_W-1:0] id, input bit err, input int wr,
                       input string tag);
    @(negedge clk);
    rx_id = id; rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
    if (err) begin
      rx_err = 1'b1;
      @(negedge clk);
      rx_err = 1'b0;
    end
    repeat (NUM_MB + 3) @(negedge clk);
    for (int b = 0; b < 7; b++) begin
      eof_tick = 1'b1; eof_bit = 3'(b);
      @(negedge clk);
      eof_tick = 1'b0;
      if (b == 5) chk({tag, " R9 move-in on 6th EOF bit"}, int'(mv_en), wr);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; queue_mode = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_code = '0;
    cfg_id = '0; cfg_mask = '0; cpu_lock = 1'b0; cpu_unlock = 1'b0; cpu_idx = '0;
    rx_start = 1'b0; rx_id = '0; rx_err = 1'b0; eof_tick = 1'b0; eof_bit = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 codes in reset", int'(mb_code_o == '0), 1);
    chk("R1 mv_en in reset", int'(mv_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cfg(0, C_INACT, 11'h123, 11'h7FF);
    cfg(2, C_EMPTY, 11'h123, 11'h7FF);
    cfg(5, C_EMPTY, 11'h123, 11'h7FF);
    cfg(6, C_TX,    11'h123, 11'h7FF);
    cfg(7, C_EMPTY, 11'h240, 11'h7F0);

    // R4 queue: first free match, then the next one
    expect_mv(2, C_FULL, "R4 frame1");
    frame(11'h123, 0, 1, "R4 frame1");
    expect_mv(5, C_FULL, "R4 frame2");
    frame(11'h123, 0, 1, "R4 frame2");
    // R5 no free match: last match overrun
    expect_mv(5, C_OVR, "R5 frame3");
    frame(11'h123, 0, 1, "R5 frame3");
    chk("R5 mb5 code", code_of(5), C_OVR);
    chk("R4 mb2 code", code_of(2), C_FULL);
    // R3 non-receive mailboxes untouched
    chk("R3 tx mailbox code", code_of(6), C_TX);
    chk("R3 inactive mailbox code", code_of(0), C_INACT);

    // R6 servicing makes mailbox 2 free again
    lock_mb(2);
    unlock_mb();
    expect_mv(2, C_FULL, "R6 serviced");
    frame(11'h123, 0, 1, "R6 serviced");

    // R8 errored frame: nothing written
    frame(11'h123, 1, 0, "R8 error");
    chk("R8 mb2 unchanged", code_of(2), C_FULL);
    chk("R8 mb5 unchanged", code_of(5), C_OVR);

    // R7 legacy: first match even though mb5 is free
    lock_mb(5);
    unlock_mb();
    queue_mode = 1'b0;
    expect_mv(2, C_OVR, "R7 legacy");
    frame(11'h123, 0, 1, "R7 legacy");
    chk("R7 mb5 untouched", code_of(5), C_OVR);
    queue_mode = 1'b1;

    // R2 mask: low nibble ignored, bit 4 compared
    expect_mv(7, C_FULL, "R2 masked hit");
    frame(11'h24A, 0, 1, "R2 masked hit");
    frame(11'h25A, 0, 0, "R2 masked miss");
    chk("R2 mb7 code", code_of(7), C_FULL);

    // R10 locked last match: pending until unlock
    lock_mb(5);
    frame(11'h123, 0, 0, "R10 pending");
    repeat (5) @(negedge clk);
    chk("R10 still pending", int'(mv_en), 0);
    expect_mv(5, C_FULL, "R10 release");
    cpu_unlock = 1'b1;
    @(negedge clk);
    cpu_unlock = 1'b0;
    chk("R10 no write at unlock edge", int'(mv_en), 0);
    @(negedge clk);
    chk("R10 write one edge after unlock", int'(mv_en), 1);
    repeat (3) @(negedge clk);
    chk("R10 mb5 code", code_of(5), C_FULL);

    chk("R4 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule